// File: doc/BRIEF.md
# Two-Key Register Write Unlock Gate

This block guards the register file of a peripheral against stray writes. After reset it is locked: every write that would reach a protected register is held back. Software opens the gate by writing a first 32-bit key word to one key address and then a second 32-bit key word to another key address. Writes to other addresses may come between the two key writes.

After an accepted second key, the gate opens after a fixed settling delay. This delay stands in for a synchronisation into a slow clock domain, so software polls the unlocked flag instead of assuming it is set at once. The flag appears as one bit of a status word that the surrounding register file places in its control register read value. Once open, the gate stays open until reset. The only effect of the gate on the protected registers is a write-enable qualifier. Reads pass unaffected, and the key addresses themselves never produce a protected write.

Top module: `keygate_top`

## Requirements
- R1: Out of reset the gate is locked: `unlocked` is 0 and `statusBits` is all zero.
- R2: Writing 0x83E70B13 to address 0x70 and then 0x95A4F1E0 to address 0x74 opens the gate.
- R3: `unlocked` and `statusBits[23]` become 1 exactly SETTLE_CYCLES clock edges after the edge that accepts the correct second key (default 3), and not earlier.
- R4: A wrong value written to address 0x70 returns the sequence to locked-idle. A second key that follows it does not open the gate.
- R5: After a correct first key, a wrong value written to address 0x74 returns the sequence to locked-idle. A later correct second key on its own then does not open the gate.
- R6: A second key written while no correct first key is pending is ignored. A full correct sequence that follows still opens the gate.
- R7: While locked, `protWrEn` is 0 for every write.
- R8: While unlocked, `protWrEn` follows `busWrEn` for every address other than 0x70 and 0x74. Writes to those two addresses never raise `protWrEn`.
- R9: Once open, the gate stays open until reset, whatever is written to the key addresses. A reset locks it again.
- R10: Writes to addresses other than the two key addresses, placed between the first and second key, do not break the sequence.
- R11: All bits of `statusBits` other than bit 23 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe of the register bus |
| busAddr | input | ADDR_W (8) | Byte address of the write |
| busWdata | input | DATA_W (32) | Write data |
| protWrEn | output | 1 | Qualified write enable for the protected registers |
| unlocked | output | 1 | Gate open flag |
| statusBits | output | DATA_W (32) | Status contribution to the control register read value; bit 23 is the open flag |

## Verification
The checker covers the properties that hold in every cycle:
- no protected write while locked;
- a pass-through of writes while open;
- no key address ever leaking a protected write;
- the open flag staying set once set;
- the status word carrying only that flag.

Only the bench's scenarios can show which key sequences open the gate and which do not. These include wrong values, the reversed order and extra writes between the keys. The bench also checks the exact cycle in which the flag appears after the second key.

// File: rtl/keygate_pkg.sv
package keygate_pkg;

  typedef enum logic [1:0] {
    GATE_LOCKED   = 2'd0,
    GATE_ARMED    = 2'd1,
    GATE_SETTLING = 2'd2,
    GATE_OPEN     = 2'd3
  } gateState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearTimer;
    logic runTimer;
    logic isOpen;
  } gateStrobes_t;

  // Decoded events from datapath to control
  typedef struct packed {
    logic firstHit;
    logic firstGood;
    logic secondHit;
    logic secondGood;
    logic settleDone;
  } keyEvents_t;

endpackage

// File: rtl/keygate_datapath.sv
module keygate_datapath
  import keygate_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter logic [ADDR_W-1:0] FIRST_ADDR  = 8'h70,
  parameter logic [ADDR_W-1:0] SECOND_ADDR = 8'h74,
  parameter logic [DATA_W-1:0] FIRST_KEY   = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] SECOND_KEY  = 32'h95A4_F1E0,
  parameter int SETTLE_CYCLES = 3,
  parameter int FLAG_BIT      = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  gateStrobes_t      strobes,
  output keyEvents_t        events,
  output logic              protWrEn,
  output logic [DATA_W-1:0] statusBits
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] settleCnt;
  logic             keyAddr;

  // Settling timer models the slow-domain synchronisation delay
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearTimer) begin
      settleCnt <= '0;
    end else if (strobes.runTimer) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  always_comb begin
    events.firstHit   = busWrEn && (busAddr == FIRST_ADDR);
    events.secondHit  = busWrEn && (busAddr == SECOND_ADDR);
    events.firstGood  = busWdata == FIRST_KEY;
    events.secondGood = busWdata == SECOND_KEY;
    events.settleDone = strobes.runTimer && (settleCnt == LAST_CNT);
  end

  assign keyAddr  = (busAddr == FIRST_ADDR) || (busAddr == SECOND_ADDR);
  assign protWrEn = busWrEn && strobes.isOpen && !keyAddr;

  always_comb begin
    statusBits           = '0;
    statusBits[FLAG_BIT] = strobes.isOpen;
  end

endmodule

// File: rtl/keygate_ctrl.sv
module keygate_ctrl
  import keygate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  keyEvents_t   events,
  output gateStrobes_t strobes
);

  gateState_t state, stateNext;
  logic acceptSecond;

  assign acceptSecond = (state == GATE_ARMED) && events.secondHit && events.secondGood;

  always_comb begin
    stateNext = state;
    unique case (state)
      GATE_LOCKED: begin
        if (events.firstHit && events.firstGood) stateNext = GATE_ARMED;
      end
      GATE_ARMED: begin
        if (events.firstHit) begin
          stateNext = events.firstGood ? GATE_ARMED : GATE_LOCKED;
        end else if (events.secondHit) begin
          stateNext = events.secondGood ? GATE_SETTLING : GATE_LOCKED;
        end
      end
      GATE_SETTLING: begin
        if (events.settleDone) stateNext = GATE_OPEN;
      end
      GATE_OPEN: stateNext = GATE_OPEN;
      default:   stateNext = GATE_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= GATE_LOCKED;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.clearTimer = acceptSecond;
    strobes.runTimer   = (state == GATE_SETTLING);
    strobes.isOpen     = (state == GATE_OPEN);
  end

endmodule

// File: rtl/keygate_top.sv
module keygate_top
  import keygate_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter logic [ADDR_W-1:0] FIRST_ADDR  = 8'h70,
  parameter logic [ADDR_W-1:0] SECOND_ADDR = 8'h74,
  parameter logic [DATA_W-1:0] FIRST_KEY   = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] SECOND_KEY  = 32'h95A4_F1E0,
  parameter int SETTLE_CYCLES = 3,
  parameter int FLAG_BIT      = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              protWrEn,
  output logic              unlocked,
  output logic [DATA_W-1:0] statusBits
);

  gateStrobes_t strobes;
  keyEvents_t   events;

  keygate_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .events  (events),
    .strobes (strobes)
  );

  keygate_datapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .FIRST_ADDR    (FIRST_ADDR),
    .SECOND_ADDR   (SECOND_ADDR),
    .FIRST_KEY     (FIRST_KEY),
    .SECOND_KEY    (SECOND_KEY),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .FLAG_BIT      (FLAG_BIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .strobes    (strobes),
    .events     (events),
    .protWrEn   (protWrEn),
    .statusBits (statusBits)
  );

  assign unlocked = strobes.isOpen;

endmodule

// File: rtl/keygate_checker.sv
module keygate_checker #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] FIRST_ADDR  = 8'h70,
  parameter logic [ADDR_W-1:0] SECOND_ADDR = 8'h74,
  parameter int FLAG_BIT = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              protWrEn,
  input logic              unlocked,
  input logic [DATA_W-1:0] statusBits
);

  logic keyAddr;
  assign keyAddr = (busAddr == FIRST_ADDR) || (busAddr == SECOND_ADDR);

  a_r1_reset_locked: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !unlocked);

  a_r7_locked_blocks: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> !protWrEn);

  a_r8_open_passes: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && busWrEn && !keyAddr) |-> protWrEn);

  a_r8_key_never_passes: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && keyAddr) |-> !protWrEn);

  a_r9_sticky_open: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |=> unlocked);

  a_r11_status_only_flag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(statusBits) && (statusBits[FLAG_BIT] == unlocked));

endmodule

bind keygate_top keygate_checker #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .FIRST_ADDR  (FIRST_ADDR),
  .SECOND_ADDR (SECOND_ADDR),
  .FLAG_BIT    (FLAG_BIT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .protWrEn   (protWrEn),
  .unlocked   (unlocked),
  .statusBits (statusBits)
);

// File: tb/tb_keygate_top.sv
module tb_keygate_top;

  localparam int SETTLE = 3;
  localparam logic [31:0] K0 = 32'h83E7_0B13;
  localparam logic [31:0] K1 = 32'h95A4_F1E0;
  localparam logic [7:0]  A0 = 8'h70;
  localparam logic [7:0]  A1 = 8'h74;

  typedef struct packed {
    logic [7:0]  addrA; logic [31:0] dataA;
    logic [7:0]  addrB; logic [31:0] dataB;
    logic [7:0]  addrC; logic [31:0] dataC;
    logic        expOpen;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{A0, K0,           A1, K1,           8'h00, 32'h0, 1'b1}, // R2 correct order
    '{A0, 32'hDEADBEEF, A1, K1,           8'h00, 32'h0, 1'b0}, // R4 wrong first
    '{A0, K0,           A1, 32'h1234_5678, A1, K1,     1'b0}, // R5 wrong second
    '{A1, K1,           A0, K0,           8'h00, 32'h0, 1'b0}, // R6 reversed
    '{A1, K1,           A0, K0,           A1, K1,       1'b1}, // R6 reversed then ok
    '{A0, K0,           8'h10, 32'hAAAA,  A1, K1,       1'b1}, // R10 gap write
    '{A0, K1,           A1, K0,           8'h00, 32'h0, 1'b0}, // R4 swapped values
    '{A0, K0,           A0, 32'h0,        A1, K1,       1'b0}, // R4 wrong first rewrite
    '{A0, K0,           A0, K0,           A1, K1,       1'b1}  // R2 repeated first
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic protWrEn, unlocked;
  logic [31:0] statusBits;

  int nCheck = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  keygate_top #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .protWrEn(protWrEn), .unlocked(unlocked),
    .statusBits(statusBits)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCheck++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; busWrEn = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWrEn = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCheck++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 unlocked", {31'b0, unlocked}, 32'd1 & 32'd0);
    check("R1 status", statusBits, 32'h0);

    // R7 locked write blocked
    @(negedge clk); busWrEn = 1'b1; busAddr = 8'h10; busWdata = 32'h5;
    #1 check("R7 locked protWrEn", {31'b0, protWrEn}, 32'd0);
    @(negedge clk); busWrEn = 1'b0;

    // Table of key sequences
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      doWrite(VECS[v].addrA, VECS[v].dataA);
      doWrite(VECS[v].addrB, VECS[v].dataB);
      doWrite(VECS[v].addrC, VECS[v].dataC);
      idle(SETTLE + 1);
      check($sformatf("R2/R4/R5/R6/R10 vector %0d", v),
            {31'b0, unlocked}, {31'b0, VECS[v].expOpen});
    end

    // R3 exact settle timing
    doReset();
    doWrite(A0, K0);
    doWrite(A1, K1);        // now half a cycle after accepting edge
    idle(SETTLE - 1);
    check("R3 not yet open", {31'b0, unlocked}, 32'd0);
    check("R3 status still clear", statusBits, 32'h0);
    idle(1);
    check("R3 open on time", {31'b0, unlocked}, 32'd1);
    check("R3 R11 status flag", statusBits, 32'h0080_0000);

    // R8 write pass-through while open
    @(negedge clk); busWrEn = 1'b1; busAddr = 8'h20; busWdata = 32'h9;
    #1 check("R8 open protWrEn", {31'b0, protWrEn}, 32'd1);
    busAddr = A0;
    #1 check("R8 key addr 0x70 blocked", {31'b0, protWrEn}, 32'd0);
    busAddr = A1;
    #1 check("R8 key addr 0x74 blocked", {31'b0, protWrEn}, 32'd0);
    @(negedge clk); busWrEn = 1'b0;
    #1 check("R8 no strobe no write", {31'b0, protWrEn}, 32'd0);

    // R9 wrong keys do not relock
    doWrite(A0, 32'h0);
    doWrite(A1, 32'hFFFF_FFFF);
    idle(SETTLE + 1);
    check("R9 stays open", {31'b0, unlocked}, 32'd1);
    doReset();
    check("R9 reset relocks", {31'b0, unlocked}, 32'd0);
    check("R11 status after reset", statusBits, 32'h0);

    done = 1'b1;
    summary();
  end

endmodule